// File: doc/BRIEF.md
# Edge Interrupt and Wake Controller

This block sits in front of a small 8-bit core and turns one external, possibly asynchronous, interrupt pin into two requests. It looks for a chosen edge on the pin (rising or falling), records it in a sticky pending flag, and then either raises a wake request while the core is halted in its low-power state or raises a vector request while the core runs. The core reads and writes the control bits through a small register port. It also reports three events: entry into sleep, retirement of an instruction, and acceptance of a vector. A return-from-interrupt strobe completes the set.

The pin is captured along two paths. In normal operation a two-flop synchronizer feeds an edge detector in the core clock domain. While asleep, a flop clocked by the pin itself catches the edge even if it is shorter than a clock period, so a wake can start with no running clock. The pending flag records edges whatever the enables say. Waking needs only the pin enable. Vectoring also needs the global enable, and after a wake the vector waits until one instruction has retired.

Top module: `eint_ctrl`

## Requirements
- R1: After reset the control word reads 4'b0100: global enable (bit 0) clear, pin enable (bit 1) clear, edge select (bit 2) set to rising, pending (bit 3) clear. The block is running, and wake and vector requests are low.
- R2: With edge select 1, a rising pin edge sets pending and a falling edge does not. Pending is set by the second clock edge after the synchronizer's first capture of the new level.
- R3: With edge select 0, a falling pin edge sets pending and a rising edge does not.
- R4: Pending sets on a valid edge whatever the global and pin enables are.
- R5: Writing 0 to bit 3 clears pending. Writing 1 to bit 3 never sets it.
- R6: When a valid edge and a pending-clear write land in the same cycle, pending ends up set.
- R7: While running, the vector request is high exactly when pending, pin enable and global enable are all set.
- R8: Accepting a vector while it is requested clears the global enable. A return-from-interrupt strobe sets it again.
- R9: While asleep, the wake request is high when pin enable and pending are set, whatever the global enable is. With pin enable clear, no wake occurs.
- R10: After a wake the vector request stays low until the next instruction-retire strobe. If the global enable is clear, no vector follows.
- R11: While asleep, a valid pin pulse shorter than a clock period raises the wake request without any clock edge, and it also sets pending.
- R12: Changing the edge select while the pin is steady does not set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 4 | Write data: bit0 global enable, bit1 pin enable, bit2 edge rising, bit3 pending (0 clears) |
| ctl_rdata_o | output | 4 | Control word, same layout |
| sleep_i | input | 1 | Core has executed its sleep instruction |
| retire_i | input | 1 | Core retired an instruction |
| vec_ack_i | input | 1 | Core takes the vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| wake_o | output | 1 | Wake request to the halted core |
| vec_req_o | output | 1 | Vector request to the running core |
| asleep_o | output | 1 | Block is in the sleep state |

## Verification
Directed pin edges are applied under both edge polarities, with the enables off and on. These show whether the polarity decode is right and whether pending is independent of the enables. A clear write timed to meet a fresh edge separates edge-wins priority from clear-wins priority. A sub-period pulse during sleep shows whether the asynchronous capture path works, because the synchronizer misses it. Random sequences of writes, pin toggles, vector accepts and returns are compared against a bench model of the control word and the vector gate.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
package eint_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_POST  = 2'd2
  } seq_e;

  localparam int CTL_W  = 4;
  localparam int GIE_B  = 0;
  localparam int PEN_B  = 1;
  localparam int RISE_B = 2;
  localparam int PEND_B = 3;
endpackage

// File: rtl/eint_sync.sv
`timescale 1ns/1ps
module eint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eint_edge_det.sv
`timescale 1ns/1ps
module eint_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic samp_i,
  input  logic rise_i,
  output logic hit_o
);
  logic prev_q;
  logic rise_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= 1'b0;
      rise_prev_q <= 1'b1;
    end else begin
      prev_q      <= samp_i;
      rise_prev_q <= rise_i;
    end
  end

  // compare only when select is steady
  assign hit_o = (rise_i == rise_prev_q) &&
                 (rise_i ? (samp_i && !prev_q) : (!samp_i && prev_q));

  a_r2_hit_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (samp_i != prev_q));
endmodule

// File: rtl/eint_wake_latch.sv
`timescale 1ns/1ps
module eint_wake_latch (
  input  logic pin_i,
  input  logic rise_i,
  input  logic clr_ni,
  output logic seen_o
);
  logic edge_clk;

  assign edge_clk = rise_i ? pin_i : !pin_i;

  // clocked by the pin; held clear unless armed
  always_ff @(posedge edge_clk or negedge clr_ni) begin
    if (!clr_ni) seen_o <= 1'b0;
    else         seen_o <= 1'b1;
  end
endmodule

// File: rtl/eint_ctrl.sv
`timescale 1ns/1ps
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  input  logic             sleep_i,
  input  logic             retire_i,
  input  logic             vec_ack_i,
  input  logic             reti_i,
  output logic             wake_o,
  output logic             vec_req_o,
  output logic             asleep_o
);
  logic gie_q, pen_q, rise_q, pend_q;
  logic pin_s, edge_hit;
  logic lat_seen, lat_s, lat_clr_n;
  logic sleep_q;
  logic pend_set;
  seq_e state_q, state_d;

  eint_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  eint_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .samp_i(pin_s), .rise_i(rise_q), .hit_o(edge_hit)
  );

  assign lat_clr_n = rst_ni && sleep_q;

  eint_wake_latch u_wlat (
    .pin_i(pin_i), .rise_i(rise_q), .clr_ni(lat_clr_n), .seen_o(lat_seen)
  );

  eint_sync #(.STAGES(SYNC_STAGES)) u_lat_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lat_seen), .q_o(lat_s)
  );

  assign pend_set = edge_hit || (sleep_q && lat_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      pen_q  <= 1'b0;
      rise_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (vec_req_o && vec_ack_i) gie_q <= 1'b0;
      else if (reti_i)            gie_q <= 1'b1;
      else if (ctl_we_i)          gie_q <= ctl_wdata_i[GIE_B];
      if (ctl_we_i) begin
        pen_q  <= ctl_wdata_i[PEN_B];
        rise_q <= ctl_wdata_i[RISE_B];
      end
      if (pend_set)                              pend_q <= 1'b1;
      else if (ctl_we_i && !ctl_wdata_i[PEND_B]) pend_q <= 1'b0;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (sleep_i)          state_d = ST_SLEEP;
      ST_SLEEP: if (pen_q && pend_q)  state_d = ST_POST;
      ST_POST:  if (retire_i)         state_d = ST_RUN;
      default:                        state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sleep_q <= (state_d == ST_SLEEP);
    end
  end

  assign ctl_rdata_o = {pend_q, rise_q, pen_q, gie_q};
  assign asleep_o    = sleep_q;
  assign wake_o      = sleep_q && pen_q && (pend_q || lat_seen);
  assign vec_req_o   = (state_q == ST_RUN) && gie_q && pen_q && pend_q;

  a_r4_edge_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_hit |=> pend_q);
  a_r5_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !(ctl_we_i && !ctl_wdata_i[PEND_B])) |=> pend_q);
  a_r7_vec_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> (!asleep_o && ctl_rdata_o[PEND_B]));
  a_r8_ack_clears_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && vec_ack_i) |=> !ctl_rdata_o[GIE_B]);
  a_r9_wake_needs_pen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ctl_rdata_o[PEN_B]);
  a_r10_hold_vec_after_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(asleep_o) && !asleep_o) |-> !vec_req_o);
endmodule

// File: tb/eint_ctrl_test.sv
`timescale 1ns/1ps
module eint_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic we = 1'b0;
  logic [3:0] wdata = 4'd0;
  logic [3:0] rdata;
  logic sleep_s = 1'b0, retire = 1'b0, ack = 1'b0, reti = 1'b0;
  logic wake, vreq, asleep;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  eint_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
    .ctl_we_i(we), .ctl_wdata_i(wdata), .ctl_rdata_o(rdata),
    .sleep_i(sleep_s), .retire_i(retire), .vec_ack_i(ack), .reti_i(reti),
    .wake_o(wake), .vec_req_o(vreq), .asleep_o(asleep)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(bit g, bit e, bit r, bit p);
    we = 1'b1; wdata = {p, r, e, g};
    tick();
    we = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    tick();
    s = 1'b0;
  endtask

  function automatic bit exp_hit(bit rise, bit oldv, bit newv);
    return rise ? (!oldv && newv) : (oldv && !newv);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit mg, me, mr, mp;
    int unsigned seed;
    seed = $urandom(32'h1c5a);
    tick(2);
    rst_n = 1'b1;
    tick();
    // R1
    chk("R1 ctl", rdata, 4'b0100);
    chk("R1 req", {wake, vreq, asleep}, 3'b000);

    // R2 / R4: rising, enables off
    pin = 1; tick(4);
    chk("R2 R4 rise sets", rdata[3], 1);
    wr(0, 0, 1, 0);
    pin = 0; tick(4);
    chk("R2 fall ignored", rdata[3], 0);

    // R3
    wr(0, 0, 0, 0); tick(2);
    pin = 1; tick(4);
    chk("R3 rise ignored", rdata[3], 0);
    pin = 0; tick(4);
    chk("R3 fall sets", rdata[3], 1);

    // R5
    wr(0, 0, 0, 1);
    chk("R5 write1 keeps", rdata[3], 1);
    wr(0, 0, 0, 0);
    chk("R5 write0 clears", rdata[3], 0);
    wr(0, 0, 0, 1);
    chk("R5 write1 no set", rdata[3], 0);

    // R12: change select, pin steady low
    wr(0, 0, 1, 0); tick(3);
    chk("R12 sel change", rdata[3], 0);
    pin = 1; tick(4); wr(0, 0, 1, 1);
    wr(0, 0, 0, 1); tick(3);
    wr(0, 0, 1, 0); tick(3);
    chk("R12 sel change pin high", rdata[3], 0);

    // R6: edge meets clear write
    pin = 0; tick(2);
    wr(0, 0, 1, 1);
    pin = 1;
    tick(2);
    we = 1; wdata = 4'b0100;
    tick();
    we = 0;
    chk("R6 edge wins", rdata[3], 1);

    // R7 / R8
    chk("R7 no gie", vreq, 0);
    wr(1, 0, 1, 1);
    chk("R7 no pen", vreq, 0);
    wr(1, 1, 1, 1);
    chk("R7 all set", vreq, 1);
    pulse(ack);
    chk("R8 ack clears gie", {rdata[0], vreq}, 2'b00);
    pulse(reti);
    chk("R8 reti sets gie", {rdata[0], vreq}, 2'b11);
    wr(1, 1, 1, 0);
    chk("R7 pend clear", vreq, 0);

    // R9: no wake with pin enable clear
    pin = 0; wr(1, 0, 1, 0); tick(3);
    pulse(sleep_s);
    chk("R9 asleep", asleep, 1);
    pin = 1; tick(5);
    chk("R9 R4 no wake pend", {wake, asleep, rdata[3]}, 3'b011);
    wr(1, 1, 1, 1);
    chk("R9 wake", wake, 1);
    tick();
    // R10 gie set: hold until retire
    chk("R10 held", {asleep, vreq}, 2'b00);
    tick(3);
    chk("R10 still held", vreq, 0);
    pulse(retire);
    chk("R10 vector after retire", vreq, 1);
    pin = 0; wr(0, 1, 1, 0); tick(3);

    // R11: short pulse while asleep, gie clear
    pulse(sleep_s);
    chk("R11 asleep", {asleep, wake}, 2'b10);
    pin = 1; #1 pin = 0; #1;
    chk("R11 wake async", wake, 1);
    tick(5);
    chk("R11 pend and left sleep", {asleep, rdata[3]}, 2'b01);
    pulse(retire);
    chk("R10 no vector gie clear", vreq, 0);
    wr(0, 0, 1, 0); tick(3);

    // random mix
    mg = 0; me = 0; mr = 1; mp = 0;
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: begin
          logic [3:0] d;
          d = 4'($urandom);
          wr(d[0], d[1], d[2], d[3]);
          mg = d[0]; me = d[1]; mr = d[2];
          if (!d[3]) mp = 0;
          tick(2);
        end
        1: begin
          bit nv;
          nv = !pin;
          if (exp_hit(mr, pin, nv)) mp = 1;
          pin = nv;
          tick(4);
        end
        2: begin
          if (mg && me && mp) mg = 0;
          pulse(ack);
        end
        default: begin
          mg = 1;
          pulse(reti);
        end
      endcase
      chk("R7 random ctl", rdata, {mp, mr, me, mg});
      chk("R7 random vec", vreq, mg && me && mp);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule